// File: doc/BRIEF.md
# Dual-Bank Wide Register File

This block is the operand store for a custom-instruction datapath that works on 128-bit vectors. It holds 32 wide registers split into two banks of 16. A single instruction can fetch up to three wide sources from anywhere in the file. It can also carry two 32-bit scalar operands, which come from a separate scalar file and pass straight through to the execution unit. It can write at most two wide results per cycle, and only when they land in different banks.

Reads are combinational: the source data for a cycle is ready in that same cycle. Writes commit at the rising clock edge. A read of a register that is being written in the same cycle returns the incoming data, so one register can serve as both source and destination of an instruction. Each write port selects its bank through its own address. There is no fixed port-to-bank wiring, and a lone write on either port may reach either bank. If two enabled writes aim at the same bank, the block flags the clash and drops both writes to that bank.

Every interface here is plain control and data with no valid/ready pairing. The file accepts one instruction's worth of reads and writes on every clock and never stalls, so it has no back-pressure path. Flow control belongs to the issuing decoder.

Top module: `dual_bank_wide_rf`

## Requirements
- R1: A synchronous reset (rst_i high at a rising edge) clears all 32 registers to zero, and afterwards every address reads zero.
- R2: A 5-bit register address uses bit 4 as the bank select (0 = bank A, also the default, 1 = bank B) and bits 3:0 as the index within the bank. Addresses 5'h03 and 5'h13 name distinct registers.
- R3: Each of the three read ports returns the content of the register it addresses in the same cycle, independently of the other read ports, for any of the 32 addresses.
- R4: An accepted write changes the register at the rising edge. The new value is read back on every later cycle until it is overwritten.
- R5: Two enabled writes whose addresses have different bank bits both take effect at the same edge.
- R6: When both write enables are high and both addresses carry the same bank bit, wr_conflict_o is high in that same cycle and neither write changes any register.
- R7: A read whose address equals an accepted write address in the same cycle returns that cycle's write data. A write dropped under R6 is not forwarded.
- R8: The two 32-bit scalar inputs appear unchanged on the scalar outputs in the same cycle.
- R9: With both write enables low, no register changes, whatever the write addresses and data are.
- R10: A single enabled write port may target either bank. Port 1 alone can write bank A, and port 0 alone can write bank B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high, clears the file |
| rd_addr_i | input | 3x5 | Read addresses, one 5-bit field per read port |
| rd_data_o | output | 3x128 | Read data, one 128-bit field per read port, with write-first forwarding |
| sc_i | input | 2x32 | Scalar operands from the scalar register file |
| sc_o | output | 2x32 | Scalar operands passed to the execution unit |
| wr_en_i | input | 2 | Write enable, one bit per write port |
| wr_addr_i | input | 2x5 | Write addresses, one 5-bit field per write port |
| wr_data_i | input | 2x128 | Write data, one 128-bit field per write port |
| wr_conflict_o | output | 1 | High when both write ports target the same bank in the current cycle |

## Verification
The read data, the scalar outputs and the conflict flag are combinational, so each one is due in the same cycle as its stimulus. A write shows in the stored contents only after the next rising edge. The bench drives inputs on the falling edge and samples the combinational results one time unit later, before the rising edge. It updates its reference model only after that rising edge, so forwarded data is compared in the write cycle and stored data in every later cycle.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  parameter int DATA_W    = 128;
  parameter int NUM_BANKS = 2;
  parameter int BANK_REGS = 16;
  parameter int NUM_RD    = 3;
  parameter int NUM_SC    = 2;
  parameter int SC_W      = 32;

  localparam int IDX_W  = $clog2(BANK_REGS);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int ADDR_W = IDX_W + BANK_W;
  localparam int NUM_WR = NUM_BANKS;
endpackage

// File: rtl/wrf_bank.sv
module wrf_bank #(
  parameter int DATA_W    = 128,
  parameter int BANK_REGS = 16,
  localparam int IDX_W    = $clog2(BANK_REGS)
) (
  input  logic                               clk_i,
  input  logic                               rst_i,
  input  logic                               we_i,
  input  logic [IDX_W-1:0]                   idx_i,
  input  logic [DATA_W-1:0]                  data_i,
  output logic [BANK_REGS-1:0][DATA_W-1:0]   regs_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      regs_o <= '0;
    end else if (we_i) begin
      regs_o[idx_i] <= data_i;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (regs_o == '0));

  // R4
  write_land_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    we_i |=> (regs_o[$past(idx_i)] == $past(data_i)));

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !we_i |=> $stable(regs_o));

endmodule

// File: rtl/wrf_write_router.sv
module wrf_write_router #(
  parameter int DATA_W    = 128,
  parameter int NUM_BANKS = 2,
  parameter int NUM_WR    = 2,
  parameter int IDX_W     = 4,
  parameter int BANK_W    = 1,
  localparam int ADDR_W   = IDX_W + BANK_W
) (
  input  logic                              clk_i,
  input  logic                              rst_i,
  input  logic [NUM_WR-1:0]                 wr_en_i,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]     wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]     wr_data_i,
  output logic [NUM_BANKS-1:0]              bank_we_o,
  output logic [NUM_BANKS-1:0][IDX_W-1:0]   bank_idx_o,
  output logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_data_o,
  output logic                              conflict_o
);

  logic [NUM_BANKS-1:0][NUM_WR-1:0] hits;
  logic [NUM_BANKS-1:0]             clash;

  always_comb begin
    hits        = '0;
    clash       = '0;
    bank_we_o   = '0;
    bank_idx_o  = '0;
    bank_data_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < NUM_WR; p++) begin
        hits[b][p] = wr_en_i[p] &&
                     (wr_addr_i[p][ADDR_W-1 -: BANK_W] == BANK_W'(b));
      end
      bank_we_o[b] = $onehot(hits[b]);
      clash[b]     = (hits[b] != '0) && !$onehot(hits[b]);
      for (int p = 0; p < NUM_WR; p++) begin
        if (hits[b][p]) begin
          bank_idx_o[b]  = wr_addr_i[p][IDX_W-1:0];
          bank_data_o[b] = wr_data_i[p];
        end
      end
    end
  end

  assign conflict_o = |clash;

  // R6
  conflict_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (conflict_o && NUM_WR == 2) |-> (bank_we_o == '0));

endmodule

// File: rtl/wrf_read_port.sv
module wrf_read_port #(
  parameter int DATA_W    = 128,
  parameter int NUM_BANKS = 2,
  parameter int BANK_REGS = 16,
  parameter int IDX_W     = 4,
  parameter int BANK_W    = 1,
  localparam int ADDR_W   = IDX_W + BANK_W
) (
  input  logic [ADDR_W-1:0]                               addr_i,
  input  logic [NUM_BANKS-1:0][BANK_REGS-1:0][DATA_W-1:0] regs_i,
  input  logic [NUM_BANKS-1:0]                            bank_we_i,
  input  logic [NUM_BANKS-1:0][IDX_W-1:0]                 bank_idx_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0]                bank_data_i,
  output logic [DATA_W-1:0]                               data_o
);

  logic [BANK_W-1:0] bsel;
  logic [IDX_W-1:0]  isel;

  assign bsel = addr_i[ADDR_W-1 -: BANK_W];
  assign isel = addr_i[IDX_W-1:0];

  always_comb begin
    data_o = regs_i[bsel][isel];
    if (bank_we_i[bsel] && (bank_idx_i[bsel] == isel)) begin
      data_o = bank_data_i[bsel];
    end
  end

endmodule

// File: rtl/dual_bank_wide_rf.sv
module dual_bank_wide_rf
  import wrf_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_i,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]    rd_addr_i,
  output logic [NUM_RD-1:0][DATA_W-1:0]    rd_data_o,
  input  logic [NUM_SC-1:0][SC_W-1:0]      sc_i,
  output logic [NUM_SC-1:0][SC_W-1:0]      sc_o,
  input  logic [NUM_WR-1:0]                wr_en_i,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]    wr_addr_i,
  input  logic [NUM_WR-1:0][DATA_W-1:0]    wr_data_i,
  output logic                             wr_conflict_o
);

  logic [NUM_BANKS-1:0]                            bank_we;
  logic [NUM_BANKS-1:0][IDX_W-1:0]                 bank_idx;
  logic [NUM_BANKS-1:0][DATA_W-1:0]                bank_data;
  logic [NUM_BANKS-1:0][BANK_REGS-1:0][DATA_W-1:0] bank_regs;

  assign sc_o = sc_i;

  wrf_write_router #(
    .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .NUM_WR(NUM_WR),
    .IDX_W(IDX_W), .BANK_W(BANK_W)
  ) u_router (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .bank_we_o   (bank_we),
    .bank_idx_o  (bank_idx),
    .bank_data_o (bank_data),
    .conflict_o  (wr_conflict_o)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wrf_bank #(
      .DATA_W(DATA_W), .BANK_REGS(BANK_REGS)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .we_i   (bank_we[b]),
      .idx_i  (bank_idx[b]),
      .data_i (bank_data[b]),
      .regs_o (bank_regs[b])
    );
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    wrf_read_port #(
      .DATA_W(DATA_W), .NUM_BANKS(NUM_BANKS), .BANK_REGS(BANK_REGS),
      .IDX_W(IDX_W), .BANK_W(BANK_W)
    ) u_rd (
      .addr_i      (rd_addr_i[r]),
      .regs_i      (bank_regs),
      .bank_we_i   (bank_we),
      .bank_idx_i  (bank_idx),
      .bank_data_i (bank_data),
      .data_o      (rd_data_o[r])
    );
  end

  // R6
  same_bank_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ((&wr_en_i) && NUM_WR == 2 &&
     (wr_addr_i[0][ADDR_W-1 -: BANK_W] == wr_addr_i[NUM_WR-1][ADDR_W-1 -: BANK_W]))
    |-> wr_conflict_o);

  // R7
  forward_first_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i[0] && !wr_conflict_o && (rd_addr_i[0] == wr_addr_i[0]))
    |-> (rd_data_o[0] == wr_data_i[0]));

endmodule

// File: tb/tb_dual_bank_wide_rf.sv
module tb_dual_bank_wide_rf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0][4:0]   rd_addr = '0;
  logic [2:0][127:0] rd_data;
  logic [1:0][31:0]  sc_in = '0;
  logic [1:0][31:0]  sc_out;
  logic [1:0]        wr_en = '0;
  logic [1:0][4:0]   wr_addr = '0;
  logic [1:0][127:0] wr_data = '0;
  logic              conflict;

  logic [127:0] mdl [32];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_bank_wide_rf dut (
    .clk_i(clk), .rst_i(rst), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sc_i(sc_in), .sc_o(sc_out), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_conflict_o(conflict)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic bit exp_conf();
    return (wr_en == 2'b11) && (wr_addr[0][4] == wr_addr[1][4]);
  endfunction

  function automatic logic [127:0] exp_rd(input logic [4:0] a);
    if (!exp_conf()) begin
      for (int p = 0; p < 2; p++)
        if (wr_en[p] && wr_addr[p] == a) return wr_data[p];
    end
    return mdl[a];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set.
  task automatic step(input string tag);
    #1;
    if (!rst) begin
      for (int i = 0; i < 3; i++)
        chk(tag, $sformatf("read port %0d addr %h", i, rd_addr[i]),
            rd_data[i], exp_rd(rd_addr[i]));
      chk("R6", "conflict flag", {127'd0, conflict}, {127'd0, exp_conf()});
      chk("R8", "scalar 0", {96'd0, sc_out[0]}, {96'd0, sc_in[0]});
      chk("R8", "scalar 1", {96'd0, sc_out[1]}, {96'd0, sc_in[1]});
    end
    @(posedge clk);
    if (rst) begin
      for (int a = 0; a < 32; a++) mdl[a] = '0;
    end else if (!exp_conf()) begin
      for (int p = 0; p < 2; p++)
        if (wr_en[p]) mdl[wr_addr[p]] = wr_data[p];
    end
    @(negedge clk);
    sc_in = {$urandom, $urandom};
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0ffee5));
    for (int a = 0; a < 32; a++) mdl[a] = 'x;
    @(negedge clk);
    rst = 1'b1;
    step("R1");
    step("R1");
    rst = 1'b0;

    // R1: every address reads zero after reset, no writes (R9 idle too)
    for (int a = 0; a < 32; a++) begin
      rd_addr[0] = 5'(a); rd_addr[1] = 5'(a ^ 1); rd_addr[2] = 5'(a ^ 16);
      step("R1");
    end

    // R5 and R7: writes to both banks at once, forwarded in the same cycle
    wr_en = 2'b11;
    wr_addr[0] = 5'h03; wr_data[0] = rnd128();
    wr_addr[1] = 5'h13; wr_data[1] = rnd128();
    rd_addr[0] = 5'h03; rd_addr[1] = 5'h13; rd_addr[2] = 5'h04;
    step("R5 R7");
    wr_en = 2'b00;
    // R2: 5'h03 and 5'h13 hold different values
    step("R2 R4");
    chk("R2", "bank A/B distinct", {127'd0, rd_data[0] != rd_data[1]}, 128'd1);

    // R10: port 1 alone into bank A, then port 0 alone into bank B
    wr_en = 2'b10; wr_addr[1] = 5'h08; wr_data[1] = rnd128();
    rd_addr[0] = 5'h08; rd_addr[1] = 5'h18; rd_addr[2] = 5'h03;
    step("R10 R7");
    wr_en = 2'b01; wr_addr[0] = 5'h1F; wr_data[0] = rnd128();
    rd_addr[0] = 5'h08; rd_addr[1] = 5'h1F; rd_addr[2] = 5'h0F;
    step("R10 R7");
    wr_en = 2'b00;
    step("R10 R4");

    // R6: same-bank clash, neither write lands nor forwards
    wr_en = 2'b11;
    wr_addr[0] = 5'h13; wr_data[0] = rnd128();
    wr_addr[1] = 5'h1A; wr_data[1] = rnd128();
    rd_addr[0] = 5'h13; rd_addr[1] = 5'h1A; rd_addr[2] = 5'h03;
    step("R6 R7");
    wr_addr[0] = 5'h05; wr_addr[1] = 5'h03;
    rd_addr[0] = 5'h05; rd_addr[1] = 5'h03; rd_addr[2] = 5'h13;
    step("R6 R7");
    wr_en = 2'b00;
    rd_addr[0] = 5'h13; rd_addr[1] = 5'h1A; rd_addr[2] = 5'h05;
    step("R6");
    rd_addr[0] = 5'h03;
    step("R6");

    // R9: enables low, addresses and data move
    for (int k = 0; k < 4; k++) begin
      wr_addr[0] = 5'h03; wr_addr[1] = 5'h13;
      wr_data[0] = rnd128(); wr_data[1] = rnd128();
      rd_addr[0] = 5'h03; rd_addr[1] = 5'h13; rd_addr[2] = 5'h08;
      step("R9");
    end

    // R3 R4 R7: random traffic
    for (int n = 0; n < 800; n++) begin
      for (int p = 0; p < 2; p++) begin
        wr_en[p]   = ($urandom_range(0, 3) != 0);
        wr_addr[p] = 5'($urandom);
        wr_data[p] = rnd128();
      end
      if ($urandom_range(0, 1) == 1) wr_addr[1][4] = ~wr_addr[0][4];
      for (int i = 0; i < 3; i++) begin
        case ($urandom_range(0, 2))
          0: rd_addr[i] = wr_addr[0];
          1: rd_addr[i] = wr_addr[1];
          default: rd_addr[i] = 5'($urandom);
        endcase
      end
      step("R3 R4 R7");
    end

    // R1: reset in mid-run clears the file
    wr_en = 2'b00;
    rst = 1'b1;
    step("R1");
    rst = 1'b0;
    for (int a = 0; a < 32; a += 3) begin
      rd_addr[0] = 5'(a); rd_addr[1] = 5'(31 - a); rd_addr[2] = 5'(a ^ 7);
      step("R1");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule